// File: doc/BRIEF.md
# Max-Log LLR and Scaled Extrinsic Unit

This block sits beside the backward recursion of a turbo component decoder that keeps its state metrics in the minimum (negative-log) domain. On each trellis step it receives the eight forward metrics of step k, the eight backward metrics of step k+1, the four branch metrics of the step, and the systematic and a-priori log-likelihood ratios of the bit. It adds forward, branch and backward metrics along all sixteen transitions. It then takes the smallest sum among the eight transitions driven by a 1 and the smallest among the eight driven by a 0. Their difference is the a-posteriori log-likelihood ratio of the bit, in the Max-Log approximation (a plain minimum with no correction term).

The systematic and a-priori parts are then removed to leave the extrinsic value. That value is multiplied by three quarters with a shift and an add, rounded, and clamped to an 8-bit signed range before it goes to the other component decoder. The unit accepts one step per clock with no stall. Each result leaves a fixed four cycles after its input, together with a valid strobe.

Top module: `maxlog_llr_unit`

## Requirements
- R1: While reset is asserted, `validOut` is 0 and `llrOut` and `extOut` are 0.
- R2: `validOut` rises exactly four clock cycles after the cycle in which `validIn` is sampled high, once per accepted step, and back-to-back inputs yield back-to-back outputs.
- R3: With metrics treated as unsigned costs, the a-posteriori value is L = min over transitions with input bit 1 of (alpha[s] + gamma + beta[next]) minus min over transitions with input bit 0 of the same sum, so a positive L means the bit is more likely 0.
- R4: The trellis state s is a 3-bit value. For input bit u, the feedback bit is a = u ^ s[1] ^ s[0], the parity is p = a ^ s[2] ^ s[0], and the next state is {a, s[2], s[1]}. State i occupies bits [i*W +: W] of `alphaIn` and `betaIn`. The branch metric of a transition is taken from slot 2*u + p of `gammaIn`.
- R5: The extrinsic value before scaling is E = L - sys - apr, using the signed `sysIn` and `aprIn`.
- R6: The scaled extrinsic is floor((3*E + 2) / 4), that is, E times 0.75 with halves rounded toward plus infinity.
- R7: `llrOut` carries L and `extOut` carries the scaled extrinsic, each clamped to the range -128 to 127.
- R8: When the two minima are equal, `llrOut` is 0 and `extOut` equals the scaled value of -(sys + apr).
- R9: On cycles when no new result is delivered, `llrOut` and `extOut` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Marks a trellis step on the metric inputs |
| alphaIn | input | 8*WM | Forward metrics of step k, state i at bits [i*WM +: WM] |
| betaIn | input | 8*WM | Backward metrics of step k+1, same packing |
| gammaIn | input | 4*WG | Branch metrics, slot 2*u+p at bits [(2*u+p)*WG +: WG] |
| sysIn | input | WX | Signed systematic LLR of the bit |
| aprIn | input | WX | Signed a-priori LLR of the bit |
| validOut | output | 1 | Result strobe, four cycles after `validIn` |
| llrOut | output | WX | Saturated a-posteriori LLR |
| extOut | output | WX | Saturated, scaled extrinsic LLR |

## Verification
The hardest situations to reach from the ports are the ones where the result depends on the exact shape of the trellis rather than on which inputs are large. Examples are a branch-metric set whose outcome changes if the slot order of u and p is swapped, and exact ties between the two minima. The bench builds these by zeroing every state metric and choosing branch metrics whose minima differ only under the correct slot order. It also builds the other extremes on purpose: maximal metric gaps in both directions to reach both clamp limits, and odd negative extrinsic values to exercise rounding. Pseudo-random back-to-back vectors with nonzero state metrics then cover the next-state wiring.

// File: rtl/maxlog_llr_pkg.sv
package maxlog_llr_pkg;

  localparam int NSTATE = 8;
  localparam int NTRANS = 2 * NSTATE;
  localparam int NBRANCH = 4;
  localparam int NSTAGE = 4;

  typedef struct packed {
    logic s1En;
    logic s2En;
    logic s3En;
    logic s4En;
  } stage_strobe_t;

  function automatic logic fbBit(input logic u, input logic [2:0] s);
    return u ^ s[1] ^ s[0];
  endfunction

  function automatic logic [2:0] trellisNext(input logic u, input logic [2:0] s);
    return {fbBit(u, s), s[2], s[1]};
  endfunction

  function automatic logic trellisParity(input logic u, input logic [2:0] s);
    return fbBit(u, s) ^ s[2] ^ s[0];
  endfunction

endpackage

// File: rtl/maxlog_llr_min_tree.sv
module maxlog_llr_min_tree #(
  parameter int N = 8,
  parameter int W = 12
) (
  input  logic [N*W-1:0] leafIn,
  output logic [W-1:0]   minOut
);

  logic [W-1:0] work [N];

  always_comb begin
    for (int i = 0; i < N; i++) work[i] = leafIn[i*W +: W];
    for (int w = N / 2; w >= 1; w = w / 2) begin
      for (int j = 0; j < w; j++) begin
        work[j] = (work[2*j] <= work[2*j+1]) ? work[2*j] : work[2*j+1];
      end
    end
    minOut = work[0];
  end

endmodule

// File: rtl/maxlog_llr_ctrl.sv
module maxlog_llr_ctrl
  import maxlog_llr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          validIn,
  output stage_strobe_t stb,
  output logic          validOut
);

  logic [NSTAGE-1:0] vPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vPipe <= '0;
    else        vPipe <= {vPipe[NSTAGE-2:0], validIn};
  end

  always_comb begin
    stb.s1En = validIn;
    stb.s2En = vPipe[0];
    stb.s3En = vPipe[1];
    stb.s4En = vPipe[2];
  end

  assign validOut = vPipe[NSTAGE-1];

  // R2: every result strobe traces back to an accepted step four cycles earlier
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    validOut |-> $past(validIn, 4));

  // R2: an accepted step always produces its strobe
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.s4En |=> validOut);

endmodule

// File: rtl/maxlog_llr_datapath.sv
module maxlog_llr_datapath
  import maxlog_llr_pkg::*;
#(
  parameter int WM = 10,
  parameter int WG = 10,
  parameter int WX = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  stage_strobe_t        stb,
  input  logic [NSTATE*WM-1:0] alphaIn,
  input  logic [NSTATE*WM-1:0] betaIn,
  input  logic [NBRANCH*WG-1:0] gammaIn,
  input  logic signed [WX-1:0] sysIn,
  input  logic signed [WX-1:0] aprIn,
  output logic signed [WX-1:0] llrOut,
  output logic signed [WX-1:0] extOut
);

  localparam int WS = ((WM > WG) ? WM : WG) + 2;
  localparam int WL = WS + 1;
  localparam int WE = WS + 3;
  localparam int WT = WE + 2;
  localparam logic signed [WT-1:0] SAT_HI = WT'((1 <<< (WX - 1)) - 1);
  localparam logic signed [WT-1:0] SAT_LO = -SAT_HI - WT'(1);

  // Stage 1: path sums along all transitions
  logic [WS-1:0] pathSum [NTRANS];
  logic [WS-1:0] pathNext [NTRANS];
  logic signed [WX-1:0] sysD1, aprD1, sysD2, aprD2;

  for (genvar t = 0; t < NTRANS; t++) begin : g_path
    localparam int U   = t / NSTATE;
    localparam int S   = t % NSTATE;
    localparam int NXT = int'(trellisNext(1'(U), 3'(S)));
    localparam int PAR = int'(trellisParity(1'(U), 3'(S)));
    assign pathNext[t] = WS'(alphaIn[S*WM +: WM])
                       + WS'(gammaIn[(2*U+PAR)*WG +: WG])
                       + WS'(betaIn[NXT*WM +: WM]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pathSum[t] <= '0;
      else if (stb.s1En) pathSum[t] <= pathNext[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sysD1 <= '0;
      aprD1 <= '0;
    end else if (stb.s1En) begin
      sysD1 <= sysIn;
      aprD1 <= aprIn;
    end
  end

  // Stage 2: per-bit minimum
  logic [NSTATE*WS-1:0] leafBus [2];
  logic [WS-1:0] minComb [2];
  logic [WS-1:0] min0R, min1R;

  for (genvar b = 0; b < 2; b++) begin : g_bit
    for (genvar s = 0; s < NSTATE; s++) begin : g_leaf
      assign leafBus[b][s*WS +: WS] = pathSum[b*NSTATE + s];
    end
    maxlog_llr_min_tree #(.N(NSTATE), .W(WS)) u_tree (
      .leafIn (leafBus[b]),
      .minOut (minComb[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min0R <= '0;
      min1R <= '0;
      sysD2 <= '0;
      aprD2 <= '0;
    end else if (stb.s2En) begin
      min0R <= minComb[0];
      min1R <= minComb[1];
      sysD2 <= sysD1;
      aprD2 <= aprD1;
    end
  end

  // Stage 3: a-posteriori difference and extrinsic removal
  logic signed [WL-1:0] llrFull, llr3;
  logic signed [WE-1:0] extFull, ext3;

  assign llrFull = $signed({1'b0, min1R}) - $signed({1'b0, min0R});
  assign extFull = WE'(llrFull) - WE'(sysD2) - WE'(aprD2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      llr3 <= '0;
      ext3 <= '0;
    end else if (stb.s3En) begin
      llr3 <= llrFull;
      ext3 <= extFull;
    end
  end

  // Stage 4: 0.75 scaling with rounding, then clamping
  function automatic logic signed [WX-1:0] satNarrow(input logic signed [WT-1:0] v);
    if (v > SAT_HI)      return SAT_HI[WX-1:0];
    else if (v < SAT_LO) return SAT_LO[WX-1:0];
    else                 return v[WX-1:0];
  endfunction

  logic signed [WT-1:0] extWide, extTriple, extScaled;

  always_comb begin
    extWide   = WT'(ext3);
    extTriple = (extWide <<< 1) + extWide + WT'(2);
    extScaled = extTriple >>> 2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      llrOut <= '0;
      extOut <= '0;
    end else if (stb.s4En) begin
      llrOut <= satNarrow(WT'(llr3));
      extOut <= satNarrow(extScaled);
    end
  end

  // R3: each selected minimum never exceeds a path it was chosen from
  p_min_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.s2En |=> (min0R <= $past(pathSum[0])) && (min1R <= $past(pathSum[NSTATE])));

  // R8: equal minima give a zero a-posteriori value
  p_tie_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.s3En && (min0R == min1R)) |=> (llr3 == '0));

  // R6: scaling keeps the sign of a non-negative extrinsic
  p_scale_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.s4En && (ext3 >= 0)) |=> (extOut >= 0));

  // R9: outputs hold without a stage-4 strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.s4En |=> ($stable(extOut) && $stable(llrOut)));

endmodule

// File: rtl/maxlog_llr_unit.sv
module maxlog_llr_unit
  import maxlog_llr_pkg::*;
#(
  parameter int WM = 10,
  parameter int WG = 10,
  parameter int WX = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  validIn,
  input  logic [8*WM-1:0]       alphaIn,
  input  logic [8*WM-1:0]       betaIn,
  input  logic [4*WG-1:0]       gammaIn,
  input  logic signed [WX-1:0]  sysIn,
  input  logic signed [WX-1:0]  aprIn,
  output logic                  validOut,
  output logic signed [WX-1:0]  llrOut,
  output logic signed [WX-1:0]  extOut
);

  stage_strobe_t stb;

  maxlog_llr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .validIn  (validIn),
    .stb      (stb),
    .validOut (validOut)
  );

  maxlog_llr_datapath #(.WM(WM), .WG(WG), .WX(WX)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .alphaIn (alphaIn),
    .betaIn  (betaIn),
    .gammaIn (gammaIn),
    .sysIn   (sysIn),
    .aprIn   (aprIn),
    .llrOut  (llrOut),
    .extOut  (extOut)
  );

  // R1: no strobe while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !validOut);

endmodule

// File: tb/maxlog_llr_unit_tb_top.sv
module maxlog_llr_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WM = 10;
  localparam int WG = 10;
  localparam int WX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic validIn = 1'b0;
  logic [8*WM-1:0] alphaIn = '0;
  logic [8*WM-1:0] betaIn = '0;
  logic [4*WG-1:0] gammaIn = '0;
  logic signed [WX-1:0] sysIn = '0;
  logic signed [WX-1:0] aprIn = '0;
  logic validOut;
  logic signed [WX-1:0] llrOut, extOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  maxlog_llr_unit #(.WM(WM), .WG(WG), .WX(WX)) dut_i (
    .clk(clk), .rst_n(rst_n), .validIn(validIn),
    .alphaIn(alphaIn), .betaIn(betaIn), .gammaIn(gammaIn),
    .sysIn(sysIn), .aprIn(aprIn),
    .validOut(validOut), .llrOut(llrOut), .extOut(extOut)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int unsigned seed = 32'h1234_5678;

  int aV [8];
  int bV [8];
  int gV [4];
  int sysV, aprV;

  int expLlr [$];
  int expExt [$];
  int expCyc [$];
  string expTag [$];
  int lastLlr = 0;
  int lastExt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Model built from R3..R8
  function automatic int nxtOf(input int u, input int s);
    int a;
    a = (u ^ (s >> 1) ^ s) & 1;
    return (a << 2) | (s >> 1);
  endfunction

  function automatic int parOf(input int u, input int s);
    int a;
    a = (u ^ (s >> 1) ^ s) & 1;
    return (a ^ (s >> 2) ^ s) & 1;
  endfunction

  function automatic int clamp8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int floorDiv4(input int v);
    if (v >= 0) return v / 4;
    return -((-v + 3) / 4);
  endfunction

  task automatic modelStep(output int l, output int e);
    int m0, m1, sm;
    m0 = 1 << 30;
    m1 = 1 << 30;
    for (int u = 0; u < 2; u++) begin
      for (int s = 0; s < 8; s++) begin
        sm = aV[s] + gV[2*u + parOf(u, s)] + bV[nxtOf(u, s)];
        if (u == 0 && sm < m0) m0 = sm;
        if (u == 1 && sm < m1) m1 = sm;
      end
    end
    l = m1 - m0;
    e = floorDiv4(3 * (l - sysV - aprV) + 2);
    l = clamp8(l);
    e = clamp8(e);
  endtask

  task automatic sendVec(input string tag);
    int l, e;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      alphaIn[s*WM +: WM] = WM'(aV[s]);
      betaIn[s*WM +: WM]  = WM'(bV[s]);
    end
    for (int g = 0; g < 4; g++) gammaIn[g*WG +: WG] = WG'(gV[g]);
    sysIn = WX'(sysV);
    aprIn = WX'(aprV);
    validIn = 1'b1;
    modelStep(l, e);
    expLlr.push_back(l);
    expExt.push_back(e);
    expCyc.push_back(cyc);
    expTag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 1'b0;
    end
  endtask

  task automatic drain();
    idle(1);
    while (expLlr.size() != 0) @(negedge clk);
    idle(2);
  endtask

  task automatic clearVec();
    for (int s = 0; s < 8; s++) begin aV[s] = 0; bV[s] = 0; end
    for (int g = 0; g < 4; g++) gV[g] = 0;
    sysV = 0;
    aprV = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && validOut) begin
      if (expLlr.size() == 0) begin
        check("R2", "unexpected validOut", 1, 0);
      end else begin
        string tg;
        int el, ee, ec;
        tg = expTag.pop_front();
        el = expLlr.pop_front();
        ee = expExt.pop_front();
        ec = expCyc.pop_front();
        check("R2", {tg, " latency"}, cyc - ec, 4);
        check(tg, "llrOut", int'(llrOut), el);
        check(tg, "extOut", int'(extOut), ee);
        lastLlr = int'(llrOut);
        lastExt = int'(extOut);
      end
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "validOut in reset", int'(validOut), 0);
    check("R1", "llrOut in reset", int'(llrOut), 0);
    check("R1", "extOut in reset", int'(extOut), 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_tie();
    clearVec();
    sendVec("R8 all zero");
    clearVec();
    sysV = 5;
    aprV = 3;
    sendVec("R8 tie with sys/apr");
    clearVec();
    sysV = -7;
    aprV = 2;
    sendVec("R8/R6 tie odd rounding");
    drain();
  endtask

  task automatic t_gamma_slot();
    clearVec();
    gV[0] = 50; gV[1] = 10; gV[2] = 70; gV[3] = 30;
    sendVec("R4 slot order");
    check("R4", "model llr for slot set", expLlr[expLlr.size()-1], 20);
    clearVec();
    aV[0] = 0;
    for (int s = 1; s < 8; s++) aV[s] = 500;
    for (int s = 0; s < 8; s++) bV[s] = 400;
    bV[4] = 0;
    gV[0] = 100; gV[1] = 100; gV[2] = 100; gV[3] = 5;
    sendVec("R4/R3 next-state from state 0");
    drain();
  endtask

  task automatic t_saturate();
    clearVec();
    gV[2] = 1023; gV[3] = 1023;
    sysV = -100; aprV = -100;
    sendVec("R7 positive clamp");
    clearVec();
    gV[0] = 1023; gV[1] = 1023;
    sysV = 100; aprV = 100;
    sendVec("R7 negative clamp");
    clearVec();
    gV[2] = 40; gV[3] = 40;
    sysV = 127; aprV = 127;
    sendVec("R5/R7 extrinsic only clamp");
    drain();
  endtask

  task automatic t_random_stream();
    for (int n = 0; n < 40; n++) begin
      for (int s = 0; s < 8; s++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        aV[s] = int'((seed >> 8) % 300);
        seed = seed * 32'd1103515245 + 32'd12345;
        bV[s] = int'((seed >> 8) % 300);
      end
      for (int g = 0; g < 4; g++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        gV[g] = int'((seed >> 8) % 200);
      end
      seed = seed * 32'd1103515245 + 32'd12345;
      sysV = int'((seed >> 8) % 121) - 60;
      seed = seed * 32'd1103515245 + 32'd12345;
      aprV = int'((seed >> 8) % 121) - 60;
      sendVec("R3/R5/R6 stream");
    end
    drain();
  endtask

  task automatic t_gap_hold();
    clearVec();
    gV[2] = 12; gV[3] = 12;
    sysV = 1;
    sendVec("R2 gapped first");
    idle(3);
    clearVec();
    gV[0] = 9; gV[1] = 9;
    aprV = -4;
    sendVec("R2 gapped second");
    drain();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R9", "validOut idle", int'(validOut), 0);
      check("R9", "llrOut held", int'(llrOut), lastLlr);
      check("R9", "extOut held", int'(extOut), lastExt);
    end
  endtask

  initial begin
    t_reset();
    t_tie();
    t_gamma_slot();
    t_saturate();
    t_random_stream();
    t_gap_hold();
    check("R2", "pending results at end", expLlr.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule